// File: doc/BRIEF.md
# Serial Controller Interrupt Aggregator

This block collects the interrupt sources of a serial controller into nine raw flags, masks them with a software-written AND mask, and drives one interrupt line toward the CPU. It watches the receive and transmit queue levels against their watermarks, the push and pop strobes of the receive queue, the controller's busy signal, a once-per-serial-clock tick and an error pulse from the flash-access path. It does not contain the shifter or the queues; it only observes them.

Two kinds of flag live side by side. Level flags follow a condition on the queues and cannot be dismissed while that condition holds. Event flags latch a one-off occurrence until software clears it. Clearing goes through a small write port: a write-one-to-clear write to the raw flags and a write to a separate clear location have the same effect. One selector value loads the mask.

A receive-idle timer counts serial clock ticks while the receive queue holds data and nobody reads it. When the count reaches its limit the timeout event fires once and the timer waits until a read or an empty queue restarts it.

Top module: `serial_irq_unit`

## Requirements
- R1: `maskedFlags` equals `rawFlags` ANDed with `maskFlags`, and `irq` is high exactly when any bit of `maskedFlags` is high; a write with `wrSel`=0 loads `wrData` into the mask, visible on `maskFlags` after that clock edge.
- R2: A write with `wrSel`=1 (raw, write-one-to-clear) or `wrSel`=2 (clear location) clears every latched event flag whose `wrData` bit is 1; both paths act identically, and `wrSel`=3 changes no flag.
- R3: Flag positions are fixed: bit 0 receive overrun, bit 1 receive timeout, bit 2 receive above watermark, bit 3 transmit below watermark, bit 4 receive not empty, bit 5 receive full, bit 6 transmit empty, bit 7 transfer end, bit 8 flash error.
- R4: One cycle after `rxLevel` is strictly greater than `rxMark`, bit 2 is 1; when `rxLevel` is at or below `rxMark`, bit 2 is 0.
- R5: One cycle after `txLevel` is strictly less than `txMark`, bit 3 is 1; when `txLevel` is at or above `txMark`, bit 3 is 0.
- R6: Bits 4, 5 and 6 follow, one cycle later, `rxLevel` not zero, `rxLevel` equal to `RX_DEPTH` (16 by default) and `txLevel` equal to zero.
- R7: A cycle with `rxPush` high, `rxPop` low and `rxLevel` equal to `RX_DEPTH` latches bit 0; a push below that level does not.
- R8: While `rxLevel` is non-zero and `rxPop` stays low, the `TIMEOUT_TICKS`-th (32 by default) `sclkTick` latches bit 1; a cycle with `rxPop` high or `rxLevel` zero restarts the count, and the flag fires only once per idle stretch.
- R9: A high-to-low change of `busy` latches bit 7; `busy` held high or rising does not.
- R10: A cycle with `flashErr` high latches bit 8.
- R11: When a flag's set condition and a clear of the same bit fall in the same cycle, the flag ends up set.
- R12: A clear of a level flag (bits 2 to 6) whose condition still holds leaves the flag at 1.
- R13: While `rstN` is low, `rawFlags`, `maskFlags`, `maskedFlags` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLevel | input | LEVEL_W | Receive queue fill level |
| txLevel | input | LEVEL_W | Transmit queue fill level |
| rxMark | input | LEVEL_W | Receive watermark |
| txMark | input | LEVEL_W | Transmit watermark |
| rxPush | input | 1 | Receive queue write strobe |
| rxPop | input | 1 | Receive queue read strobe |
| busy | input | 1 | Controller busy |
| sclkTick | input | 1 | One-cycle pulse per serial clock period |
| flashErr | input | 1 | Flash-access error pulse |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | 0 mask, 1 raw write-one-to-clear, 2 clear location, 3 none |
| wrData | input | 9 | Write data, one bit per flag |
| rawFlags | output | 9 | Raw flag state |
| maskFlags | output | 9 | Current mask |
| maskedFlags | output | 9 | Raw flags ANDed with mask |
| irq | output | 1 | CPU interrupt |

## Verification
The hardest state to reach is the receive timeout's boundary: the flag must stay low after 31 ticks, rise on the 32nd, not rise again after a clear while the queue stays idle, and restart from zero after a read or an empty cycle. The stimulus holds the receive level at full with a tick every cycle, inserts a read after 20 ticks and an empty cycle later, and samples the flag on the exact counts either side of the limit. The watermark comparisons are swept over every level and watermark pair of the default configuration, and the mask over all 512 values against a latched mix of set and clear flags.

// File: rtl/serial_irq_pkg.sv
package serial_irq_pkg;

  localparam int NUM_FLAGS = 9;

  typedef enum int unsigned {
    FLG_OVR     = 0,
    FLG_TMO     = 1,
    FLG_RXWM    = 2,
    FLG_TXWM    = 3,
    FLG_RXNE    = 4,
    FLG_RXFULL  = 5,
    FLG_TXEMPTY = 6,
    FLG_XFEREND = 7,
    FLG_FLASH   = 8
  } flagIdx_e;

  typedef enum logic [1:0] {
    WSEL_MASK = 2'd0,
    WSEL_RAW  = 2'd1,
    WSEL_CLR  = 2'd2,
    WSEL_NONE = 2'd3
  } wrSel_e;

  // bits that follow a condition rather than latching an event
  localparam logic [NUM_FLAGS-1:0] LEVEL_BITS = 9'b0_0111_1100;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] evSet;
    logic [NUM_FLAGS-1:0] lvlNow;
    logic [NUM_FLAGS-1:0] clr;
    logic                 maskWe;
    logic [NUM_FLAGS-1:0] maskVal;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import serial_irq_pkg::*;
#(
  parameter int LEVEL_W       = 5,
  parameter int RX_DEPTH      = 16,
  parameter int TIMEOUT_TICKS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LEVEL_W-1:0]   rxLevel,
  input  logic [LEVEL_W-1:0]   txLevel,
  input  logic [LEVEL_W-1:0]   rxMark,
  input  logic [LEVEL_W-1:0]   txMark,
  input  logic                 rxPush,
  input  logic                 rxPop,
  input  logic                 busy,
  input  logic                 sclkTick,
  input  logic                 flashErr,
  input  logic                 wrEn,
  input  logic [1:0]           wrSel,
  input  logic [NUM_FLAGS-1:0] wrData,
  output ctrlStrobe_t          strb
);

  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0]   CNT_LIMIT = CNT_W'(TIMEOUT_TICKS);
  localparam logic [CNT_W-1:0]   CNT_LAST  = CNT_W'(TIMEOUT_TICKS - 1);
  localparam logic [LEVEL_W-1:0] FULL_LVL  = LEVEL_W'(RX_DEPTH);

  logic             busyQ;
  logic [CNT_W-1:0] idleCnt;
  logic             rxEmpty;
  logic             idleRestart;
  logic             tmoHit;

  assign rxEmpty     = (rxLevel == '0);
  assign idleRestart = rxEmpty || rxPop;
  assign tmoHit      = !idleRestart && sclkTick && (idleCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      idleCnt <= '0;
    end else begin
      busyQ <= busy;
      if (idleRestart)
        idleCnt <= '0;
      else if (sclkTick && idleCnt != CNT_LIMIT)
        idleCnt <= idleCnt + 1'b1;
    end
  end

  always_comb begin
    strb = '0;
    strb.evSet[FLG_OVR]     = rxPush && !rxPop && (rxLevel == FULL_LVL);
    strb.evSet[FLG_TMO]     = tmoHit;
    strb.evSet[FLG_XFEREND] = busyQ && !busy;
    strb.evSet[FLG_FLASH]   = flashErr;

    strb.lvlNow[FLG_RXWM]    = rxLevel > rxMark;
    strb.lvlNow[FLG_TXWM]    = txLevel < txMark;
    strb.lvlNow[FLG_RXNE]    = !rxEmpty;
    strb.lvlNow[FLG_RXFULL]  = rxLevel == FULL_LVL;
    strb.lvlNow[FLG_TXEMPTY] = txLevel == '0;

    strb.clr     = (wrEn && (wrSel == WSEL_RAW || wrSel == WSEL_CLR)) ? wrData : '0;
    strb.maskWe  = wrEn && (wrSel == WSEL_MASK);
    strb.maskVal = wrData;
  end

  // R8: the idle counter never runs past its limit
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= CNT_LIMIT);

  // R8: one timeout per idle stretch, never on consecutive cycles
  a_r8_tmo_once: assert property (@(posedge clk) disable iff (!rstN)
    strb.evSet[FLG_TMO] |=> !strb.evSet[FLG_TMO]);

  // R8: a read restarts the count from zero
  a_r8_pop_restart: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |=> idleCnt == '0);

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import serial_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strb,
  output logic [NUM_FLAGS-1:0] rawFlags,
  output logic [NUM_FLAGS-1:0] maskFlags,
  output logic [NUM_FLAGS-1:0] maskedFlags,
  output logic                 irq
);

  logic [NUM_FLAGS-1:0] rawQ;
  logic [NUM_FLAGS-1:0] rawNext;
  logic [NUM_FLAGS-1:0] maskQ;

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    if (LEVEL_BITS[k]) begin : g_lvl
      assign rawNext[k] = strb.lvlNow[k];
    end else begin : g_evt
      assign rawNext[k] = strb.evSet[k] | (rawQ[k] & ~strb.clr[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ  <= '0;
      maskQ <= '0;
    end else begin
      rawQ <= rawNext;
      if (strb.maskWe)
        maskQ <= strb.maskVal;
    end
  end

  assign rawFlags    = rawQ;
  assign maskFlags   = maskQ;
  assign maskedFlags = rawQ & maskQ;
  assign irq         = |maskedFlags;

  // R11: every event raised in a cycle is set afterwards, clear or not
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.evSet) |=> ((rawQ & $past(strb.evSet)) == $past(strb.evSet)));

  // R2: a clear without a competing event drops the event flag
  a_r2_clear_event: assert property (@(posedge clk) disable iff (!rstN)
    (|(strb.clr & ~strb.evSet & ~LEVEL_BITS))
      |=> ((rawQ & $past(strb.clr & ~strb.evSet & ~LEVEL_BITS)) == '0));

  // R1: a mask write lands on the next cycle
  a_r1_mask_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskWe |=> maskQ == $past(strb.maskVal));

  // R12: a level flag tracks its condition regardless of clears
  a_r12_level_holds: assert property (@(posedge clk) disable iff (!rstN)
    (|(strb.lvlNow & strb.clr)) |=> ((rawQ & $past(strb.lvlNow & strb.clr)) != '0));

endmodule

// File: rtl/serial_irq_unit.sv
module serial_irq_unit
  import serial_irq_pkg::*;
#(
  parameter int LEVEL_W       = 5,
  parameter int RX_DEPTH      = 16,
  parameter int TIMEOUT_TICKS = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [LEVEL_W-1:0] txLevel,
  input  logic [LEVEL_W-1:0] rxMark,
  input  logic [LEVEL_W-1:0] txMark,
  input  logic               rxPush,
  input  logic               rxPop,
  input  logic               busy,
  input  logic               sclkTick,
  input  logic               flashErr,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [8:0]         wrData,
  output logic [8:0]         rawFlags,
  output logic [8:0]         maskFlags,
  output logic [8:0]         maskedFlags,
  output logic               irq
);

  ctrlStrobe_t strb;

  irq_event_ctrl #(
    .LEVEL_W      (LEVEL_W),
    .RX_DEPTH     (RX_DEPTH),
    .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxLevel (rxLevel),
    .txLevel (txLevel),
    .rxMark  (rxMark),
    .txMark  (txMark),
    .rxPush  (rxPush),
    .rxPop   (rxPop),
    .busy    (busy),
    .sclkTick(sclkTick),
    .flashErr(flashErr),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .strb    (strb)
  );

  irq_flag_bank u_bank (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rawFlags   (rawFlags),
    .maskFlags  (maskFlags),
    .maskedFlags(maskedFlags),
    .irq        (irq)
  );

  // R4: receive watermark compare, one cycle later
  a_r4_rx_above: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel > rxMark) |=> rawFlags[FLG_RXWM]);
  a_r4_rx_not_above: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel <= rxMark) |=> !rawFlags[FLG_RXWM]);

  // R5: transmit watermark compare, one cycle later
  a_r5_tx_below: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel < txMark) |=> rawFlags[FLG_TXWM]);
  a_r5_tx_not_below: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel >= txMark) |=> !rawFlags[FLG_TXWM]);

  // R9: a falling busy leaves the transfer-end flag set
  a_r9_xfer_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |=> rawFlags[FLG_XFEREND]);

  // R8: the timeout flag only rises while data waits
  a_r8_tmo_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawFlags[FLG_TMO]) |-> $past(rxLevel != '0));

endmodule

// File: tb/sim_serial_irq_unit.sv
`timescale 1ns/1ps
module sim_serial_irq_unit;

  logic       clk = 1'b0;
  logic       rstN;
  logic [4:0] rxLevel, txLevel, rxMark, txMark;
  logic       rxPush, rxPop, busy, sclkTick, flashErr, wrEn;
  logic [1:0] wrSel;
  logic [8:0] wrData;
  logic [8:0] rawFlags, maskFlags, maskedFlags;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  serial_irq_unit u0 (
    .clk(clk), .rstN(rstN), .rxLevel(rxLevel), .txLevel(txLevel),
    .rxMark(rxMark), .txMark(txMark), .rxPush(rxPush), .rxPop(rxPop),
    .busy(busy), .sclkTick(sclkTick), .flashErr(flashErr), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .rawFlags(rawFlags), .maskFlags(maskFlags),
    .maskedFlags(maskedFlags), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #5;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [8:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    cyc();
    wrEn = 1'b0; wrSel = 2'd3; wrData = '0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; rxLevel = '0; txLevel = '0; rxMark = '0; txMark = '0;
    rxPush = 0; rxPop = 0; busy = 0; sclkTick = 0; flashErr = 0;
    wrEn = 0; wrSel = 2'd3; wrData = '0;
    repeat (3) cyc();
    // R13: reset state
    chk(rawFlags == 0 && maskFlags == 0, "R13 raw/mask", {rawFlags, maskFlags}, 0);
    chk(maskedFlags == 0 && irq == 0, "R13 masked/irq", {maskedFlags, irq}, 0);
    rstN = 1'b1;
    cyc();
    // R6 / R3: only transmit empty (bit 6) with both queues empty
    chk(rawFlags == 9'h040, "R6 idle pattern", rawFlags, 9'h040);

    // R4 R6: receive sweep, transmit side neutral
    txLevel = 5'd8; txMark = 5'd0;
    for (int l = 0; l <= 16; l++) begin
      for (int m = 0; m < 16; m++) begin
        rxLevel = 5'(l); rxMark = 5'(m);
        cyc();
        chk(rawFlags[2] == (l > m), "R4 rx watermark", rawFlags[2], int'(l > m));
        chk(rawFlags[4] == (l != 0) && rawFlags[5] == (l == 16), "R6 rx level flags",
            rawFlags[5:4], {l == 16, l != 0});
      end
    end
    // R5 R6: transmit sweep
    rxLevel = '0; rxMark = '0;
    for (int l = 0; l <= 16; l++) begin
      for (int m = 0; m <= 16; m++) begin
        txLevel = 5'(l); txMark = 5'(m);
        cyc();
        chk(rawFlags[3] == (l < m), "R5 tx watermark", rawFlags[3], int'(l < m));
        chk(rawFlags[6] == (l == 0), "R6 tx empty", rawFlags[6], int'(l == 0));
      end
    end
    txLevel = 5'd8; txMark = 5'd4;
    cyc();
    chk(rawFlags == 0, "R3 neutral", rawFlags, 0);

    // R9: rising / held busy does not set, falling does
    busy = 1; cyc(); cyc();
    chk(rawFlags[7] == 0, "R9 busy high", rawFlags[7], 0);
    busy = 0; cyc();
    chk(rawFlags[7] == 1, "R9 busy fall", rawFlags[7], 1);
    // R10
    flashErr = 1; cyc(); flashErr = 0; cyc();
    chk(rawFlags[8] == 1, "R10 flash error latched", rawFlags[8], 1);
    // R7: push below full is harmless, push at full latches
    rxLevel = 5'd15; rxMark = 5'd16; rxPush = 1; cyc();
    chk(rawFlags[0] == 0, "R7 push below full", rawFlags[0], 0);
    rxLevel = 5'd16; cyc(); rxPush = 0; cyc();
    chk(rawFlags[0] == 1, "R7 overrun latched", rawFlags[0], 1);
    // R2: both clear paths, selector 3 ignored
    wr(2'd3, 9'h1FF);
    chk(rawFlags[0] && rawFlags[7] && rawFlags[8], "R2 sel3 ignored",
        {rawFlags[8:7], rawFlags[0]}, 3'b111);
    wr(2'd1, 9'h001);
    chk(rawFlags[0] == 0 && rawFlags[8], "R2 raw w1c", {rawFlags[8], rawFlags[0]}, 2'b10);
    wr(2'd2, 9'h100);
    chk(rawFlags[8] == 0 && rawFlags[7], "R2 clear location", rawFlags[8:7], 2'b10);
    wr(2'd2, 9'h080);
    chk(rawFlags[7] == 0, "R2 clear xfer end", rawFlags[7], 0);
    // R12: level flags survive a clear while their condition holds
    wr(2'd1, 9'h1FF);
    chk(rawFlags[4] && rawFlags[5], "R12 level flags hold", rawFlags[5:4], 2'b11);

    // R8: timeout with a read in the middle
    sclkTick = 1;
    repeat (20) cyc();
    rxPop = 1; cyc(); rxPop = 0;
    repeat (31) cyc();
    chk(rawFlags[1] == 0, "R8 31 ticks after read", rawFlags[1], 0);
    cyc();
    chk(rawFlags[1] == 1, "R8 32nd tick", rawFlags[1], 1);
    wr(2'd1, 9'h002);
    repeat (40) cyc();
    chk(rawFlags[1] == 0, "R8 fires once", rawFlags[1], 0);
    rxLevel = '0; cyc(); rxLevel = 5'd16;
    repeat (31) cyc();
    chk(rawFlags[1] == 0, "R8 31 ticks after empty", rawFlags[1], 0);
    cyc();
    chk(rawFlags[1] == 1, "R8 restart after empty", rawFlags[1], 1);
    sclkTick = 0;

    // R11: set and clear of bit 8 in one cycle
    flashErr = 1; wr(2'd2, 9'h100); flashErr = 0;
    chk(rawFlags[8] == 1, "R11 set wins", rawFlags[8], 1);

    // R1: build 0x1B7 then sweep every mask value
    rxMark = 5'd15;
    rxPush = 1; cyc(); rxPush = 0;
    busy = 1; cyc(); busy = 0; cyc();
    cyc();
    chk(rawFlags == 9'h1B7, "R3 mixed pattern", rawFlags, 9'h1B7);
    for (int m = 0; m < 512; m++) begin
      wr(2'd0, 9'(m));
      chk(maskFlags == 9'(m) && maskedFlags == (9'h1B7 & 9'(m)), "R1 masked flags",
          maskedFlags, 9'h1B7 & 9'(m));
      chk(irq == ((9'h1B7 & 9'(m)) != 0), "R1 irq line", irq, int'((9'h1B7 & 9'(m)) != 0));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule